// File: doc/BRIEF.md
# Reset Filter, Clock Divider and Boot Sequencer

The block sits between the oscillator and reset pin of a small controller and the rest of the chip. It divides the oscillator by two to make a square clock output. It watches an active-low reset pin through a synchronizer and only honours a reset that has stayed low long enough. When the pin rises again, it steps through a fixed boot sequence of ten state times, where one state time is one clock-output period.

The clock output is realigned at release so that the first state time starts on a rising half. During the first state time a one-cycle strobe tells the core to clear its status word. From the second state time the block requests one byte from the configuration address, and it latches the returned byte as the configuration value. In the second half of the tenth state time it pulses a program-counter load with the fixed start address.

An external-access select pin is captured while reset is held and kept afterwards. A reset that is recognised in the middle of the sequence aborts it. A low pulse that is too short has no effect anywhere.

Top module: `rstboot_seq`

## Requirements
- R1: `clkout` changes level on every oscillator edge, which gives half the oscillator rate at 50% duty. The one exception is the cycle in which a boot sequence starts: there `clkout` may repeat the high level.
- R2: a reset is recognised only when `rst_pin_n` has been low for at least 8 consecutive oscillator cycles (4 state times). A shorter low pulse while idle produces no `psw_clr`, no `rd_req`, no `cfg_load` and no `pc_load`, and it leaves `cfg_byte` and `ea_latched` unchanged.
- R3: when `rst_pin_n` rises after a recognised reset, the first state time of the boot starts in the oscillator cycle that follows the third rising edge that samples the pin high (two synchronizer stages plus one register). `clkout` is high in that cycle.
- R4: the sequence lasts ten state times. `pc_load` appears 19 oscillator cycles after `psw_clr`, provided the configuration byte has already arrived.
- R5: `psw_clr` is a single one-cycle pulse in the first half of the first state time, once per boot. It never coincides with `pc_load`.
- R6: `rd_req` rises at the first half of the second state time with `rd_addr` = 0x2018. It stays high until `rd_valid` is sampled high, and it is low from the next cycle on.
- R7: the byte on `rd_data` is captured on an edge where both `rd_req` and `rd_valid` are high. In the following cycle `cfg_byte` holds that byte and `cfg_load` pulses for one cycle. `cfg_byte` does not change at any other time.
- R8: `pc_load` pulses for one cycle with `pc_value` = 0x2080 in the second half of the tenth state time. If the byte has not been captured by then, the sequence stays in the tenth state time and pulses `pc_load` in the first second-half cycle after the capture.
- R9: `ea_latched` follows `ea_pin` on every edge while a reset is recognised, and holds its value at all other times.
- R10: a reset recognised during a boot ends it at once, with no `pc_load`, and the next release runs a complete new boot. A low pulse shorter than 8 cycles during a boot does not alter its timing.
- R11: while `arst_n` is low, `clkout` is high, all strobes and `rd_req` are low, and `cfg_byte` and `ea_latched` are 0. The block leaves `arst_n` low as if a reset were recognised, so the first rise of `rst_pin_n` starts a boot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous power-on clear, active low |
| rst_pin_n | input | 1 | Reset pin, active low, asynchronous to nothing in particular |
| ea_pin | input | 1 | External-access select pin |
| rd_data | input | 8 | Read response byte |
| rd_valid | input | 1 | Read response valid |
| clkout | output | 1 | Half-rate clock output |
| rd_req | output | 1 | Read request, held until answered |
| rd_addr | output | 16 | Read address (configuration byte address) |
| cfg_byte | output | 8 | Latched configuration byte |
| cfg_load | output | 1 | One-cycle strobe: `cfg_byte` was just updated |
| psw_clr | output | 1 | One-cycle strobe: clear the status word |
| pc_load | output | 1 | One-cycle strobe: load `pc_value` into the program counter |
| pc_value | output | 16 | Start address for the program counter |
| ea_latched | output | 1 | External-access select captured during reset |

## Verification
The byte capture and the jump can land in the same oscillator cycle. This happens when the read response is delayed so that the byte is captured on the edge that enters the second half of the tenth state time. The bench sweeps the response delay from zero to beyond that point. For each delay it computes the cycle at which `cfg_load` is expected and the first odd cycle at or after both the nominal jump slot and the capture, and it requires both strobes at exactly those samples. When the delay is 16, both strobes appear in the same sample. A second coincidence, a recognised reset arriving mid-boot just before the release, is provoked by an 8-cycle low pulse inside a boot. It is judged by the absence of the first jump and by exact timing of the restarted boot.

// File: rtl/rstboot_pkg.sv
package rstboot_pkg;

    // Half of a state time: HIGH is the first half (clock output high).
    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_e;

    function automatic phase_e phase_flip(input phase_e p);
        return (p == PH_HIGH) ? PH_LOW : PH_HIGH;
    endfunction

endpackage

// File: rtl/rstboot_sync.sv
module rstboot_sync #(
    parameter int   STAGES    = 2,
    parameter logic RST_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign chain_d[i] = din;
        end else begin : g_next
            assign chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= {STAGES{RST_LEVEL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/rstboot_lowfilt.sv
module rstboot_lowfilt #(
    parameter int MIN_LOW_STATES = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic rst_s,
    input  logic ea_pin,
    output logic in_reset,
    output logic rel_pulse,
    output logic ea_latched
);

    localparam int LOW_CYC = 2 * MIN_LOW_STATES;
    localparam int CW      = (LOW_CYC > 1) ? $clog2(LOW_CYC) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(LOW_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          in_rst;
        logic          ea;
    } lf_t;

    localparam lf_t LF_RST = '{cnt: '0, in_rst: 1'b1, ea: 1'b0};

    lf_t r_d;
    lf_t r_q;

    always_comb begin
        r_d = r_q;
        if (rst_s) begin
            r_d.cnt    = '0;
            r_d.in_rst = 1'b0;
        end else begin
            if (r_q.cnt == CNT_TOP) begin
                r_d.in_rst = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
        if (r_q.in_rst) begin
            r_d.ea = ea_pin;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            r_q <= LF_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_reset   = r_q.in_rst;
    assign rel_pulse  = r_q.in_rst & rst_s;
    assign ea_latched = r_q.ea;

endmodule

// File: rtl/rstboot_clkgen.sv
module rstboot_clkgen
    import rstboot_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic realign,
    output logic clkout,
    output logic ph_last
);

    typedef struct packed {
        phase_e ph;
    } cg_t;

    cg_t r_d;
    cg_t r_q;

    always_comb begin
        r_d = r_q;
        if (realign) begin
            r_d.ph = PH_HIGH;
        end else begin
            r_d.ph = phase_flip(r_q.ph);
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            r_q.ph <= PH_HIGH;
        end else begin
            r_q <= r_d;
        end
    end

    assign clkout  = (r_q.ph == PH_HIGH);
    assign ph_last = (r_q.ph == PH_LOW);

endmodule

// File: rtl/rstboot_fsm.sv
module rstboot_fsm #(
    parameter int BOOT_STATES = 10,
    parameter int CLR_STATE   = 0,
    parameter int FETCH_STATE = 1,
    parameter int DW          = 8
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          in_reset,
    input  logic          rel_pulse,
    input  logic          ph_last,
    input  logic [DW-1:0] rd_data,
    input  logic          rd_valid,
    output logic          rd_req,
    output logic [DW-1:0] cfg_byte,
    output logic          cfg_load,
    output logic          psw_clr,
    output logic          pc_load
);

    localparam int ST_W = (BOOT_STATES > 1) ? $clog2(BOOT_STATES) : 1;
    localparam logic [ST_W-1:0] ST_LAST  = ST_W'(BOOT_STATES - 1);
    localparam logic [ST_W-1:0] ST_CLR   = ST_W'(CLR_STATE);
    localparam logic [ST_W-1:0] ST_FETCH = ST_W'(FETCH_STATE);

    typedef struct packed {
        logic            busy;
        logic [ST_W-1:0] st;
        logic            got;
        logic [DW-1:0]   cfg;
        logic            cfg_load;
    } fsm_t;

    localparam fsm_t FSM_RST = '{busy: 1'b0, st: '0, got: 1'b0, cfg: '0, cfg_load: 1'b0};

    fsm_t r_d;
    fsm_t r_q;
    logic req_w;
    logic run_w;

    assign run_w = r_q.busy & ~in_reset;
    assign req_w = run_w & ~r_q.got & (r_q.st >= ST_FETCH);

    always_comb begin
        r_d          = r_q;
        r_d.cfg_load = 1'b0;

        if (req_w && rd_valid) begin
            r_d.cfg      = rd_data;
            r_d.got      = 1'b1;
            r_d.cfg_load = 1'b1;
        end

        if (r_q.busy && ph_last) begin
            if (r_q.st == ST_LAST) begin
                if (r_q.got) begin
                    r_d.busy = 1'b0;
                end
            end else begin
                r_d.st = r_q.st + 1'b1;
            end
        end

        if (in_reset) begin
            r_d.busy = 1'b0;
        end

        if (rel_pulse) begin
            r_d.busy = 1'b1;
            r_d.st   = '0;
            r_d.got  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            r_q <= FSM_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req   = req_w;
    assign cfg_byte = r_q.cfg;
    assign cfg_load = r_q.cfg_load;
    assign psw_clr  = run_w & (r_q.st == ST_CLR) & ~ph_last;
    assign pc_load  = run_w & (r_q.st == ST_LAST) & ph_last & r_q.got;

endmodule

// File: rtl/rstboot_seq.sv
module rstboot_seq #(
    parameter int            MIN_LOW_STATES = 4,
    parameter int            BOOT_STATES    = 10,
    parameter int            SYNC_STAGES    = 2,
    parameter int            CLR_STATE      = 0,
    parameter int            FETCH_STATE    = 1,
    parameter int            DW             = 8,
    parameter int            AW             = 16,
    parameter logic [AW-1:0] CFG_ADDR       = 16'h2018,
    parameter logic [AW-1:0] START_ADDR     = 16'h2080
) (
    input  logic          clk_osc,
    input  logic          arst_n,
    input  logic          rst_pin_n,
    input  logic          ea_pin,
    input  logic [DW-1:0] rd_data,
    input  logic          rd_valid,
    output logic          clkout,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] cfg_byte,
    output logic          cfg_load,
    output logic          psw_clr,
    output logic          pc_load,
    output logic [AW-1:0] pc_value,
    output logic          ea_latched
);

    logic rst_s_w;
    logic in_reset_w;
    logic rel_pulse_w;
    logic ph_last_w;

    rstboot_sync #(
        .STAGES    (SYNC_STAGES),
        .RST_LEVEL (1'b0)
    ) u_sync (
        .clk    (clk_osc),
        .arst_n (arst_n),
        .din    (rst_pin_n),
        .dout   (rst_s_w)
    );

    rstboot_lowfilt #(
        .MIN_LOW_STATES (MIN_LOW_STATES)
    ) u_lowfilt (
        .clk        (clk_osc),
        .arst_n     (arst_n),
        .rst_s      (rst_s_w),
        .ea_pin     (ea_pin),
        .in_reset   (in_reset_w),
        .rel_pulse  (rel_pulse_w),
        .ea_latched (ea_latched)
    );

    rstboot_clkgen u_clkgen (
        .clk     (clk_osc),
        .arst_n  (arst_n),
        .realign (rel_pulse_w),
        .clkout  (clkout),
        .ph_last (ph_last_w)
    );

    rstboot_fsm #(
        .BOOT_STATES (BOOT_STATES),
        .CLR_STATE   (CLR_STATE),
        .FETCH_STATE (FETCH_STATE),
        .DW          (DW)
    ) u_fsm (
        .clk       (clk_osc),
        .arst_n    (arst_n),
        .in_reset  (in_reset_w),
        .rel_pulse (rel_pulse_w),
        .ph_last   (ph_last_w),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .rd_req    (rd_req),
        .cfg_byte  (cfg_byte),
        .cfg_load  (cfg_load),
        .psw_clr   (psw_clr),
        .pc_load   (pc_load)
    );

    assign rd_addr  = CFG_ADDR;
    assign pc_value = START_ADDR;

endmodule

// File: rtl/rstboot_checker.sv
module rstboot_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          arst_n,
    input logic          clkout,
    input logic          rd_req,
    input logic          rd_valid,
    input logic [DW-1:0] rd_data,
    input logic [DW-1:0] cfg_byte,
    input logic          cfg_load,
    input logic          psw_clr,
    input logic          pc_load,
    input logic          ea_latched,
    input logic          in_reset,
    input logic          rel_pulse
);

    assert_clk_toggle_R1: assert property (@(posedge clk) disable iff (!arst_n)
        !rel_pulse |=> (clkout != $past(clkout)));

    assert_release_start_R3: assert property (@(posedge clk) disable iff (!arst_n)
        rel_pulse |=> (clkout && psw_clr));

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!arst_n)
        $onehot0({psw_clr, pc_load}));

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!arst_n)
        (rd_req && !rd_valid && !in_reset) |=> rd_req);

    assert_req_drop_R6: assert property (@(posedge clk) disable iff (!arst_n)
        (rd_req && rd_valid) |=> !rd_req);

    assert_capture_R7: assert property (@(posedge clk) disable iff (!arst_n)
        (rd_req && rd_valid) |=> (cfg_load && (cfg_byte == $past(rd_data))));

    assert_cfg_stable_R7: assert property (@(posedge clk) disable iff (!arst_n)
        !cfg_load |-> $stable(cfg_byte));

    assert_jump_after_fetch_R8: assert property (@(posedge clk) disable iff (!arst_n)
        pc_load |-> !rd_req);

    assert_ea_hold_R9: assert property (@(posedge clk) disable iff (!arst_n)
        !in_reset |=> $stable(ea_latched));

    assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!arst_n)
        (in_reset && !rel_pulse) |=> (!rd_req && !pc_load && !psw_clr));

endmodule

bind rstboot_seq rstboot_checker #(.DW(DW)) u_chk (
    .clk        (clk_osc),
    .arst_n     (arst_n),
    .clkout     (clkout),
    .rd_req     (rd_req),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .cfg_byte   (cfg_byte),
    .cfg_load   (cfg_load),
    .psw_clr    (psw_clr),
    .pc_load    (pc_load),
    .ea_latched (ea_latched),
    .in_reset   (in_reset_w),
    .rel_pulse  (rel_pulse_w)
);

// File: tb/rstboot_seq_bench.sv
`timescale 1ns/1ps
module rstboot_seq_bench;

    localparam int DW     = 8;
    localparam int AW     = 16;
    localparam int BOOT   = 10;
    localparam int PSW_N  = 2;
    localparam int PC_N   = PSW_N + 2 * BOOT - 1;
    localparam int REQ_N  = PSW_N + 2;

    logic          clk_osc   = 1'b0;
    logic          arst_n    = 1'b0;
    logic          rst_pin_n = 1'b0;
    logic          ea_pin    = 1'b0;
    logic [DW-1:0] rd_data   = '0;
    logic          rd_valid  = 1'b0;
    logic          clkout;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] cfg_byte;
    logic          cfg_load;
    logic          psw_clr;
    logic          pc_load;
    logic [AW-1:0] pc_value;
    logic          ea_latched;

    rstboot_seq u_rstboot_seq (
        .clk_osc    (clk_osc),
        .arst_n     (arst_n),
        .rst_pin_n  (rst_pin_n),
        .ea_pin     (ea_pin),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .clkout     (clkout),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .cfg_byte   (cfg_byte),
        .cfg_load   (cfg_load),
        .psw_clr    (psw_clr),
        .pc_load    (pc_load),
        .pc_value   (pc_value),
        .ea_latched (ea_latched)
    );

    always #2 clk_osc = ~clk_osc;

    int total = 0;
    int bad   = 0;

    int psw_cnt, psw_first, psw_last, psw_clk_bad;
    int pc_cnt, pc_first, pcv_err;
    int cfg_cnt, cfg_first, cfg_val;
    int rd_first, rd_last, addr_err, clk_err;
    logic ea_exp;
    logic [DW-1:0] cfg_exp;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk_osc);
        #1;
    endtask

    // Hold the pin low for low_len cycles, release it and watch n_mon samples.
    task automatic run_boot(input int low_len, input int delay, input logic [DW-1:0] data,
                            input logic ea_v, input int g_at, input int g_len, input int n_mon);
        int   waitc;
        logic prev_clk;
        ea_pin    = ea_v;
        rst_pin_n = 1'b0;
        for (int i = 0; i < low_len; i++) tick();
        rst_pin_n = 1'b1;
        psw_cnt = 0; psw_first = -1; psw_last = -1; psw_clk_bad = 0;
        pc_cnt = 0; pc_first = -1; pcv_err = 0;
        cfg_cnt = 0; cfg_first = -1; cfg_val = -1;
        rd_first = -1; rd_last = -1; addr_err = 0; clk_err = 0;
        waitc    = 0;
        prev_clk = clkout;
        for (int n = 0; n < n_mon; n++) begin
            tick();
            if (psw_clr) begin
                psw_cnt++;
                if (psw_first < 0) psw_first = n;
                psw_last = n;
                if (!clkout) psw_clk_bad++;
            end
            if (pc_load) begin
                pc_cnt++;
                if (pc_first < 0) pc_first = n;
                if (pc_value != 16'h2080) pcv_err++;
            end
            if (cfg_load) begin
                cfg_cnt++;
                if (cfg_first < 0) cfg_first = n;
                cfg_val = int'(cfg_byte);
            end
            if (rd_req) begin
                if (rd_first < 0) rd_first = n;
                rd_last = n;
                if (rd_addr != 16'h2018) addr_err++;
            end
            if ((clkout == prev_clk) && !(psw_clr && clkout)) clk_err++;
            prev_clk = clkout;
            if (rd_req) begin
                if (waitc >= delay) begin
                    rd_valid = 1'b1;
                    rd_data  = data;
                end else begin
                    rd_valid = 1'b0;
                    waitc++;
                end
            end else begin
                rd_valid = 1'b0;
                waitc    = 0;
            end
            if (n == g_at) rst_pin_n = 1'b0;
            if (n == g_at + g_len) rst_pin_n = 1'b1;
            if (n == 5) ea_pin = ~ea_v;
        end
        rd_valid = 1'b0;
    endtask

    function automatic int pc_slot(input int delay);
        int s;
        s = (PC_N > REQ_N + 1 + delay) ? PC_N : (REQ_N + 1 + delay);
        if ((s % 2) != (PC_N % 2)) s++;
        return s;
    endfunction

    task automatic check_full_boot(input int delay, input logic [DW-1:0] data);
        chk(psw_cnt == 1, "R5", "psw_clr count", psw_cnt, 1);
        chk(psw_first == PSW_N, "R3", "psw_clr cycle after release", psw_first, PSW_N);
        chk(psw_clk_bad == 0, "R3", "clkout low during first half", psw_clk_bad, 0);
        chk(clk_err == 0, "R1", "clkout failed to toggle", clk_err, 0);
        chk(rd_first == REQ_N, "R6", "rd_req first cycle", rd_first, REQ_N);
        chk(rd_last == REQ_N + delay, "R6", "rd_req last cycle", rd_last, REQ_N + delay);
        chk(addr_err == 0, "R6", "rd_addr mismatches", addr_err, 0);
        chk(cfg_cnt == 1, "R7", "cfg_load count", cfg_cnt, 1);
        chk(cfg_first == REQ_N + 1 + delay, "R7", "cfg_load cycle", cfg_first, REQ_N + 1 + delay);
        chk(cfg_val == int'(data), "R7", "cfg_byte", cfg_val, int'(data));
        chk(pc_cnt == 1, "R8", "pc_load count", pc_cnt, 1);
        chk(pc_first == pc_slot(delay), "R8", "pc_load cycle", pc_first, pc_slot(delay));
        chk(pcv_err == 0, "R8", "pc_value mismatches", pcv_err, 0);
    endtask

    initial begin
        #600000;
        bad++;
        total++;
        $display("FAIL watchdog R4 actual=timeout expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R11: state while the power-on clear is held
        ea_pin = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        chk(clkout == 1'b1, "R11", "clkout in clear", int'(clkout), 1);
        chk(!psw_clr && !pc_load && !cfg_load, "R11", "strobes in clear", int'({psw_clr, pc_load, cfg_load}), 0);
        chk(rd_req == 1'b0, "R11", "rd_req in clear", int'(rd_req), 0);
        chk(cfg_byte == '0, "R11", "cfg_byte in clear", int'(cfg_byte), 0);
        chk(ea_latched == 1'b0, "R11", "ea_latched in clear", int'(ea_latched), 0);
        arst_n = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        chk(ea_latched == 1'b1, "R11", "ea_latched follows pin after clear", int'(ea_latched), 1);

        // R11 / R4: first pin rise boots without a further low period
        run_boot(0, 1, 8'hA5, 1'b1, -1, 0, 40);
        check_full_boot(1, 8'hA5);
        chk(pc_first - psw_first == 2 * BOOT - 1, "R4", "psw_clr to pc_load distance", pc_first - psw_first, 2 * BOOT - 1);
        chk(ea_latched == 1'b1, "R9", "ea_latched held after release", int'(ea_latched), 1);
        ea_exp  = 1'b1;
        cfg_exp = 8'hA5;

        // R8 / R7: sweep of response delay, covering the stall and the coincident strobes
        for (int d = 0; d <= 20; d++) begin
            logic [DW-1:0] dv;
            dv = DW'(d * 37 + 5);
            run_boot(8, d, dv, d[0], -1, 0, 40);
            check_full_boot(d, dv);
            chk(ea_latched == d[0], "R9", "ea_latched after boot", int'(ea_latched), int'(d[0]));
            ea_exp  = d[0];
            cfg_exp = dv;
        end

        // R2: low-length sweep from idle
        for (int l = 1; l <= 12; l++) begin
            logic [DW-1:0] dv;
            logic ev;
            dv = DW'(l * 11 + 3);
            ev = ~ea_exp;
            run_boot(l, 2, dv, ev, -1, 0, 40);
            if (l >= 8) begin
                check_full_boot(2, dv);
                ea_exp  = ev;
                cfg_exp = dv;
            end else begin
                chk(psw_cnt == 0, "R2", "psw_clr on short pulse", psw_cnt, 0);
                chk(rd_first < 0, "R2", "rd_req on short pulse", rd_first, -1);
                chk(cfg_cnt == 0, "R2", "cfg_load on short pulse", cfg_cnt, 0);
                chk(pc_cnt == 0, "R2", "pc_load on short pulse", pc_cnt, 0);
                chk(clk_err == 0, "R1", "clkout toggling while idle", clk_err, 0);
            end
            chk(cfg_byte == cfg_exp, "R2", "cfg_byte after pulse", int'(cfg_byte), int'(cfg_exp));
            chk(ea_latched == ea_exp, "R9", "ea_latched after pulse", int'(ea_latched), int'(ea_exp));
        end

        // R10: short glitch inside a boot leaves its timing alone
        run_boot(9, 0, 8'h3C, 1'b0, 6, 3, 40);
        check_full_boot(0, 8'h3C);

        // R10: recognised reset inside a boot aborts it, then a new boot runs
        run_boot(8, 0, 8'hC3, 1'b0, 6, 8, 50);
        chk(psw_cnt == 2, "R10", "psw_clr count with abort", psw_cnt, 2);
        chk(psw_last == 17, "R10", "restarted boot start", psw_last, 17);
        chk(pc_cnt == 1, "R10", "pc_load count with abort", pc_cnt, 1);
        chk(pc_first == 17 + 2 * BOOT - 1, "R10", "pc_load of restarted boot", pc_first, 17 + 2 * BOOT - 1);
        chk(cfg_cnt == 2, "R10", "cfg_load count with abort", cfg_cnt, 2);
        chk(clk_err == 0, "R1", "clkout toggling around abort", clk_err, 0);
        chk(ea_latched == 1'b1, "R9", "ea_latched taken at second reset", int'(ea_latched), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule